// File: doc/BRIEF.md
# Programmable Hysteresis Threshold Switch

This block turns a stream of signed, digitized field samples into one switch level. Each strobed sample is compared against an operate threshold picked by a 7-bit code and against a release threshold. The release threshold always sits a fixed hysteresis below the operate threshold. A sample above the operate threshold pulls the active-low switch output low, which means a target is present. A sample below the release threshold drives it high again. A sample between the two thresholds leaves the output as it was.

A range-sign input moves the operate threshold downward from its base value instead of upward. It does not change the sense of the output. The output is high from reset, before any sample arrives. A separate valid flag stays low until a power-on delay counter has run out.

Top module: `hyst_switch`

## Requirements
- R1: With `range_neg` = 0, the operate threshold is BASE + `thr_code` × STEP. `thr_code` is unsigned, 0 to 127.
- R2: The release threshold is the operate threshold minus HYST. A strobed sample greater than or equal to the release threshold and less than or equal to the operate threshold leaves `sw_n` unchanged.
- R3: A strobed sample strictly greater than the operate threshold drives `sw_n` to 0 one clock after the strobe edge. A sample equal to the threshold does not.
- R4: A strobed sample strictly less than the release threshold drives `sw_n` to 1 one clock after the strobe edge.
- R5: While `rst_n` is 0, `sw_n` is 1 and `sw_vld` is 0, with no sample needed.
- R6: With `range_neg` = 1, the operate threshold is BASE − `thr_code` × STEP. A sample above it still drives `sw_n` low, so the output polarity is unchanged.
- R7: `sw_vld` goes to 1 on the POR_CYCLES-th rising clock edge after reset is released and then stays at 1.
- R8: When no strobe is present, `sw_n` holds its last value whatever `smp` does.
- R9: Asserting reset again forces `sw_n` high, clears `sw_vld` and restarts the delay count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SAMPLE_W | Signed field sample |
| thr_code | input | 7 | Operate-threshold code |
| range_neg | input | 1 | Moves the threshold range downward |
| sw_n | output | 1 | Active-low switch level |
| sw_vld | output | 1 | Output valid after the power-on delay |

## Verification
A sample strobe and the end of the power-on delay can fall on the same clock edge. The bench provokes this after a second reset by placing a strobe whose sample is above the operate threshold on exactly the POR_CYCLES-th edge. It then requires that on the following half cycle `sw_n` has fallen and `sw_vld` has risen together, with neither event hiding the other. Threshold-equal samples on both edges of the hysteresis band are also checked, to find an off-by-one comparison.

// File: rtl/hyst_switch.sv
module hyst_switch #(
  parameter int SAMPLE_W   = 12,
  parameter int CODE_W     = 7,
  parameter int BASE       = 200,
  parameter int STEP       = 8,
  parameter int HYST       = 40,
  parameter int POR_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic [CODE_W-1:0]          thr_code,
  input  logic                       range_neg,
  output logic                       sw_n,
  output logic                       sw_vld
);
  localparam int TW = SAMPLE_W + 2;
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic signed [TW-1:0] BASE_T = TW'(BASE);
  localparam logic signed [TW-1:0] STEP_T = TW'(STEP);
  localparam logic signed [TW-1:0] HYST_T = TW'(HYST);
  localparam logic [CW-1:0]        POR_T  = CW'(POR_CYCLES);

  logic signed [TW-1:0] code_x, mag, op_thr, rel_thr, smp_x;
  logic [CW-1:0]        por_cnt;

  assign code_x  = {{(TW-CODE_W){1'b0}}, thr_code};
  assign mag     = code_x * STEP_T;
  assign op_thr  = range_neg ? BASE_T - mag : BASE_T + mag;
  assign rel_thr = op_thr - HYST_T;
  assign smp_x   = {{(TW-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_n <= 1'b1;
    end else if (smp_vld) begin
      if (smp_x > op_thr)       sw_n <= 1'b0;
      else if (smp_x < rel_thr) sw_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              por_cnt <= '0;
    else if (por_cnt != POR_T) por_cnt <= por_cnt + 1'b1;
  end

  assign sw_vld = (por_cnt == POR_T);
endmodule

// File: rtl/hyst_switch_chk.sv
module hyst_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic sw_n,
  input logic sw_vld
);
  a_r3_fall_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_n) |-> $past(smp_vld));
  a_r4_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_n) |-> $past(smp_vld));
  a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(sw_n));
  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vld |=> sw_vld);
  a_r5_reset_state: assert property (@(posedge clk)
    !rst_n |=> (sw_n && !sw_vld) || rst_n);
endmodule

bind hyst_switch hyst_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sw_n(sw_n), .sw_vld(sw_vld)
);

// File: tb/sim_hyst_switch.sv
module sim_hyst_switch;
  localparam int SW = 12, BASE = 200, STEP = 8, HYST = 40, POR = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [SW-1:0] smp = '0;
  logic [6:0] thr_code = '0;
  logic range_neg = 1'b0;
  logic sw_n, sw_vld;

  int checks = 0, errors = 0;
  int mdl = 1;
  bit exp_q[$];
  string tag_q[$];
  bit arm = 1'b0;

  always #2 clk = ~clk;

  hyst_switch u0 (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
                  .thr_code(thr_code), .range_neg(range_neg), .sw_n(sw_n), .sw_vld(sw_vld));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int s, input int code, input bit neg, input string tag);
    int op;
    op = neg ? BASE - code * STEP : BASE + code * STEP;
    if (s > op) mdl = 0;
    else if (s < op - HYST) mdl = 1;
    @(negedge clk);
    smp = SW'(s); thr_code = 7'(code); range_neg = neg; smp_vld = 1'b1;
    exp_q.push_back(mdl[0]);
    tag_q.push_back(tag);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  always @(posedge clk) arm <= smp_vld;

  always @(negedge clk) begin
    if (arm && exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(sw_n == e, t, sw_n, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sw_n == 1'b1, "R5 reset sw_n", sw_n, 1);
    check(sw_vld == 1'b0, "R5 reset sw_vld", sw_vld, 0);
    rst_n = 1'b1;
    repeat (POR - 1) @(negedge clk);
    check(sw_vld == 1'b0, "R7 before delay", sw_vld, 0);
    check(sw_n == 1'b1, "R5 power-on level kept", sw_n, 1);
    @(negedge clk);
    check(sw_vld == 1'b1, "R7 at delay", sw_vld, 1);

    apply(200, 0, 0, "R3 equal op no switch");
    apply(201, 0, 0, "R3 above op");
    apply(180, 0, 0, "R2 in band hold low");
    apply(160, 0, 0, "R2 equal release hold");
    apply(159, 0, 0, "R4 below release");
    apply(250, 10, 0, "R1 code10 below op");
    apply(281, 10, 0, "R1 code10 above op");
    apply(241, 10, 0, "R2 code10 band");
    apply(239, 10, 0, "R4 code10 release");
    apply(1217, 127, 0, "R1 code127 above op");
    apply(1175, 127, 0, "R4 code127 release");
    apply(-199, 50, 1, "R6 neg above op low");
    apply(-230, 50, 1, "R6 neg band hold");
    apply(-241, 50, 1, "R6 neg release high");
    apply(-815, 127, 1, "R6 neg127 above op");
    apply(-857, 127, 1, "R6 neg127 release");
    apply(500, 0, 0, "R3 drive low for hold");

    @(negedge clk);
    smp = -SW'(1000);
    repeat (5) @(negedge clk);
    check(sw_n == 1'b0, "R8 no strobe hold", sw_n, 0);
    check(sw_vld == 1'b1, "R7 stays valid", sw_vld, 1);

    rst_n = 1'b0;
    @(negedge clk);
    check(sw_n == 1'b1, "R9 reset forces high", sw_n, 1);
    check(sw_vld == 1'b0, "R9 reset clears valid", sw_vld, 0);
    rst_n = 1'b1;
    mdl = 1;
    repeat (POR - 1) @(negedge clk);
    check(sw_vld == 1'b0, "R9 count restarted", sw_vld, 0);
    smp = SW'(400); thr_code = 7'd0; range_neg = 1'b0; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check(sw_vld == 1'b1, "R7 valid with strobe same edge", sw_vld, 1);
    check(sw_n == 1'b0, "R3 switch with valid same edge", sw_n, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule